// File: doc/BRIEF.md
# EDO DRAM Refresh and Power-Up Sequencer

This block generates all refresh traffic for an EDO DRAM that is refreshed with CAS-before-RAS cycles. After reset it holds the strobes inactive for the power-up pause. It then runs a fixed number of initialization refresh cycles and only afterwards raises `ready`, which tells the access controller that normal reads and writes may begin.

During normal operation an interval timer adds one unit of refresh debt per refresh period, and the block requests the strobe bus while debt is outstanding. When the access controller grants the request, the sequencer drives one CBR cycle itself: CAS falls, then RAS falls, CAS rises, RAS rises, and a precharge gap follows. Debt left unserved builds up to a small cap, and the request stays high until the debt is paid off.

A sleep input puts the DRAM into self-refresh. Before entry the block runs a full burst of refreshes over all rows. It then holds RAS and CAS low for longer than the self-refresh threshold. On release it waits out the exit precharge and runs a second full burst before raising `ready` again. All timings are given in nanoseconds and converted into clock cycles from a clock-period parameter.

Top module: `edo_refresh_seq`

## Requirements
- R1: After reset is released, `ras_n` and `cas_n` stay high and `ready` stays low for at least the power-up pause (`PAUSE_NS` rounded up to whole cycles).
- R2: After the pause, exactly `INIT_CYCLES` CBR cycles are issued before `ready` rises, and no request is raised before then.
- R3: In every refresh cycle, `cas_n` falls at least `CSR_NS` (in cycles) before `ras_n` falls. After `ras_n` falls, `cas_n` stays low for at least `CHR_NS`.
- R4: In each CBR cycle, `ras_n` stays low for at least `RAS_NS`. `ras_n` stays high for at least `RP_NS` before the next fall, and for at least `RPS_NS` after a self-refresh.
- R5: `we_n` is high at all times.
- R6: While `ready` is high, one unit of debt is added every `REF_NS` (rounded down to cycles). `ref_req` is high exactly when the block is idle, `ready` is high and the debt is non-zero. The first request appears `REF_NS` cycles after `ready` rises.
- R7: Debt saturates at `DEBT_MAX`. After a long period with no grant, granting continuously yields exactly `DEBT_MAX` refresh cycles before `ref_req` drops.
- R8: If `ref_gnt` is high while `ref_req` is high at a clock edge, then at that edge `cas_n` goes low, `ref_active` goes high and `ref_req` goes low. Each accepted grant produces exactly one CBR cycle.
- R9: `sleep_req` has no effect unless `ready` is high, the block is idle and the debt is zero.
- R10: An accepted sleep request lowers `ready` and starts CAS low at the same edge. It then runs `BURST_ROWS` CBR cycles, and afterwards holds `ras_n` and `cas_n` low for at least the self-refresh time (`RASS_NS` in cycles plus one) and for as long as `sleep_req` stays high.
- R11: On exit from self-refresh, `ras_n` stays high for at least `RPS_NS`, then `BURST_ROWS` CBR cycles follow, and then `ready` rises with the debt cleared.
- R12: Whenever `ref_active` is low, `ras_n` and `cas_n` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh request to the access controller |
| ref_gnt | input | 1 | Grant of the strobe bus from the access controller |
| ref_active | output | 1 | The sequencer is driving the strobes |
| sleep_req | input | 1 | Request to enter and stay in self-refresh |
| ready | output | 1 | Normal DRAM accesses are allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |

## Verification
The hardest state to reach is debt saturation that lines up with a known timer phase. The bench keeps its own copy of the refresh phase, counted from the rise of `ready`. It withholds grants for many intervals and then grants continuously just after an interval boundary, so that no new debt can arrive while the backlog is served. Self-refresh is entered only after the bench has cleared all debt at a chosen phase. It is exercised twice: once with a long sleep request, and once with a brief pulse that must still produce the minimum hold. A separate sleep attempt is made while a request is pending, to show that the sleep input is ignored then.

// File: rtl/edo_refresh_seq.sv
module edo_refresh_seq #(
  parameter int CLK_PS      = 5000,
  parameter int PAUSE_NS    = 200000,
  parameter int INIT_CYCLES = 8,
  parameter int REF_NS      = 15600,
  parameter int BURST_ROWS  = 4096,
  parameter int DEBT_MAX    = 8,
  parameter int CSR_NS      = 5,
  parameter int CHR_NS      = 10,
  parameter int RAS_NS      = 60,
  parameter int RP_NS       = 40,
  parameter int RASS_NS     = 100000,
  parameter int RPS_NS      = 110
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_gnt,
  output logic ref_active,
  input  logic sleep_req,
  output logic ready,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);

  function automatic int up_cyc(longint ns);
    longint c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int dn_cyc(longint ns);
    longint c;
    c = (ns * 1000) / CLK_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_PAUSE = up_cyc(PAUSE_NS);
  localparam int T_CSR   = up_cyc(CSR_NS);
  localparam int T_CHR   = up_cyc(CHR_NS);
  localparam int T_RAS   = up_cyc(RAS_NS);
  localparam int T_RLO   = imax(1, T_RAS - T_CHR);
  localparam int T_RP    = up_cyc(RP_NS);
  localparam int T_RASS  = up_cyc(RASS_NS) + 1;
  localparam int T_RPS   = up_cyc(RPS_NS);
  localparam int T_REF   = imax(2, dn_cyc(REF_NS));
  localparam int T_MAX   = imax(imax(T_PAUSE, T_RASS),
                                imax(imax(T_RPS, T_RP), imax(T_RLO, imax(T_CHR, T_CSR))));
  localparam int TW = $clog2(T_MAX + 1);
  localparam int RW = $clog2(T_REF);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam int LW = $clog2(imax(INIT_CYCLES, BURST_ROWS) + 1);

  typedef enum logic [3:0] {
    S_PAUSE, S_IDLE, S_CSU, S_RLC, S_RLO, S_RPR, S_SSU, S_SHD, S_SEX
  } st_t;

  typedef enum logic [1:0] {CX_INIT, CX_NORM, CX_ENTER, CX_EXIT} cx_t;

  st_t st, nst;
  cx_t cx, ncx;
  logic [TW-1:0] tmr;
  logic [LW-1:0] left, nleft;
  logic [DW-1:0] debt;
  logic [RW-1:0] itv;
  logic ras_q, cas_q;
  logic tdone, tick, grant_ok, sleep_ok, exit_done;

  function automatic logic [TW-1:0] dur(st_t s);
    case (s)
      S_PAUSE: return TW'(T_PAUSE - 1);
      S_CSU:   return TW'(T_CSR - 1);
      S_RLC:   return TW'(T_CHR - 1);
      S_RLO:   return TW'(T_RLO - 1);
      S_RPR:   return TW'(T_RP - 1);
      S_SSU:   return TW'(T_CSR - 1);
      S_SHD:   return TW'(T_RASS - 1);
      S_SEX:   return TW'(T_RPS - 1);
      default: return '0;
    endcase
  endfunction

  assign ready      = (cx == CX_NORM);
  assign tdone      = (tmr == '0);
  assign ref_req    = (st == S_IDLE) && ready && (debt != '0);
  assign ref_active = (st != S_IDLE);
  assign grant_ok   = ref_req && ref_gnt;
  assign sleep_ok   = sleep_req && ready && (debt == '0);
  assign tick       = ready && (itv == RW'(T_REF - 1));
  assign exit_done  = (st == S_RPR) && tdone && (cx == CX_EXIT) && (left == LW'(1));
  assign ras_n      = ras_q;
  assign cas_n      = cas_q;
  assign we_n       = 1'b1;

  always_comb begin
    nst   = st;
    ncx   = cx;
    nleft = left;
    case (st)
      S_PAUSE: if (tdone) begin nst = S_CSU; nleft = LW'(INIT_CYCLES); end
      S_IDLE: begin
        if (grant_ok) nst = S_CSU;
        else if (sleep_ok) begin
          nst = S_CSU; ncx = CX_ENTER; nleft = LW'(BURST_ROWS);
        end
      end
      S_CSU: if (tdone) nst = S_RLC;
      S_RLC: if (tdone) nst = S_RLO;
      S_RLO: if (tdone) nst = S_RPR;
      S_RPR: if (tdone) begin
        if (cx == CX_NORM) nst = S_IDLE;
        else if (left > LW'(1)) begin nst = S_CSU; nleft = left - LW'(1); end
        else if (cx == CX_ENTER) nst = S_SSU;
        else begin nst = S_IDLE; ncx = CX_NORM; end
      end
      S_SSU: if (tdone) nst = S_SHD;
      S_SHD: if (tdone && !sleep_req) nst = S_SEX;
      S_SEX: if (tdone) begin nst = S_CSU; ncx = CX_EXIT; nleft = LW'(BURST_ROWS); end
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_PAUSE;
      cx    <= CX_INIT;
      left  <= '0;
      tmr   <= TW'(T_PAUSE - 1);
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      st    <= nst;
      cx    <= ncx;
      left  <= nleft;
      if (nst != st) tmr <= dur(nst);
      else if (!tdone) tmr <= tmr - TW'(1);
      ras_q <= !(nst inside {S_RLC, S_RLO, S_SHD});
      cas_q <= !(nst inside {S_CSU, S_RLC, S_SSU, S_SHD});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ready || tick) itv <= '0;
    else itv <= itv + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || exit_done || (st == S_IDLE && sleep_ok)) debt <= '0;
    else begin
      case ({tick, grant_ok})
        2'b10: if (debt != DW'(DEBT_MAX)) debt <= debt + DW'(1);
        2'b01: debt <= debt - DW'(1);
        default: debt <= debt;
      endcase
    end
  end

  assert_cas_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  assert_debt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DW'(DEBT_MAX));

  assert_sleep_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(sleep_req) && $past(debt == '0) && $past(st == S_IDLE));

  assert_idle_strobes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_active |-> ras_n && cas_n);

  assert_req_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready && ras_n && cas_n);

endmodule

// File: tb/edo_refresh_seq_bench.sv
`timescale 1ns/1ps
module edo_refresh_seq_bench;

  localparam int CLK_PS = 5000, PAUSE_NS = 1000, INIT_CYCLES = 8, REF_NS = 2000;
  localparam int BURST_ROWS = 16, DEBT_MAX = 8, RASS_NS = 500;

  function automatic int up_c(longint ns);
    longint c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int dn_c(longint ns);
    longint c;
    c = (ns * 1000) / CLK_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int T_PAUSE = up_c(PAUSE_NS);
  localparam int T_CSR = up_c(5), T_CHR = up_c(10), T_RAS = up_c(60), T_RP = up_c(40);
  localparam int T_RPS = up_c(110), T_RASS = up_c(RASS_NS) + 1, T_REF = dn_c(REF_NS);
  localparam int T_CBR = T_CSR + T_RAS + T_RP;

  logic clk = 0, rst_n = 0, ref_gnt = 0, sleep_req = 0;
  logic ref_req, ref_active, ready, ras_n, cas_n, we_n;

  edo_refresh_seq #(.CLK_PS(CLK_PS), .PAUSE_NS(PAUSE_NS), .INIT_CYCLES(INIT_CYCLES),
    .REF_NS(REF_NS), .BURST_ROWS(BURST_ROWS), .DEBT_MAX(DEBT_MAX), .RASS_NS(RASS_NS))
  u_edo_refresh_seq (.clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ref_active(ref_active), .sleep_req(sleep_req), .ready(ready),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n));

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int cas_fall_c = 0, ras_fall_c = 0, ras_rise_c = 0, first_cas_c = -1;
  int cbr_cnt = 0, self_cnt = 0, self_len = 0, we_bad = 0, idle_bad = 0, len = 0;
  bit prev_ras = 1, prev_cas = 1, after_self = 0;
  int rel_c, r0, base, bself, acc, t0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!we_n) we_bad++;
      if (!ref_active && (!ras_n || !cas_n)) idle_bad++;
      if (prev_cas && !cas_n) begin
        cas_fall_c = cyc;
        if (first_cas_c < 0) first_cas_c = cyc;
      end
      if (prev_ras && !ras_n) begin
        chk(!cas_n && (cyc - cas_fall_c >= T_CSR), "R3 cas lead", cyc - cas_fall_c, T_CSR);
        chk(cyc - ras_rise_c >= (after_self ? T_RPS : T_RP), "R4 precharge",
            cyc - ras_rise_c, after_self ? T_RPS : T_RP);
        after_self = 0;
        ras_fall_c = cyc;
      end
      if (!prev_cas && cas_n && !prev_ras)
        chk(cyc - ras_fall_c >= T_CHR, "R3 cas hold", cyc - ras_fall_c, T_CHR);
      if (!prev_ras && ras_n) begin
        len = cyc - ras_fall_c;
        if (len >= T_RASS) begin
          self_cnt++; self_len = len; after_self = 1;
        end else begin
          chk(len >= T_RAS, "R4 ras low", len, T_RAS);
          cbr_cnt++;
        end
        ras_rise_c = cyc;
      end
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
    if (cyc == 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  task automatic clear_debt();
    ref_gnt = 1;
    @(negedge clk);
    while (ref_req || ref_active) @(negedge clk);
    ref_gnt = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 reset strobes", {ras_n, cas_n}, 3);
    chk(!ready && !ref_req, "R1 reset flags", {ready, ref_req}, 0);
    rst_n = 1; rel_c = cyc;
    sleep_req = 1;
    repeat (5) @(negedge clk);
    sleep_req = 0;
    while (!ready) begin
      if (ref_req) chk(0, "R2 early request", 1, 0);
      @(negedge clk);
    end
    r0 = cyc;
    chk(first_cas_c - rel_c >= T_PAUSE, "R1 pause", first_cas_c - rel_c, T_PAUSE);
    chk(cbr_cnt == INIT_CYCLES, "R2 init count R9 sleep ignored", cbr_cnt, INIT_CYCLES);
    chk(!ref_req, "R6 no debt at ready", ref_req, 0);

    while (!ref_req) @(negedge clk);
    chk(cyc - r0 == T_REF, "R6 interval", cyc - r0, T_REF);

    base = cbr_cnt;
    ref_gnt = 1;
    @(negedge clk);
    ref_gnt = 0;
    chk(!cas_n && ras_n, "R8 cas on grant", {ras_n, cas_n}, 2);
    chk(ref_active && !ref_req, "R8 handshake", {ref_active, ref_req}, 2);
    while (ref_active) @(negedge clk);
    chk(cbr_cnt - base == 1, "R8 one cycle per grant", cbr_cnt - base, 1);

    repeat (12 * T_REF) @(negedge clk);
    while ((cyc - r0) % T_REF != 2) @(negedge clk);
    base = cbr_cnt;
    ref_gnt = 1;
    repeat (DEBT_MAX * T_CBR + 30) @(negedge clk);
    ref_gnt = 0;
    chk(cbr_cnt - base == DEBT_MAX, "R7 debt cap", cbr_cnt - base, DEBT_MAX);
    chk(!ref_req, "R7 request cleared", ref_req, 0);

    base = cbr_cnt; acc = 0;
    for (int i = 0; i < 3000; i++) begin
      ref_gnt = ($urandom % 4) == 0;
      if (ref_gnt && ref_req) acc++;
      @(negedge clk);
    end
    ref_gnt = 0;
    repeat (T_CBR + 10) @(negedge clk);
    chk(cbr_cnt - base == acc, "R8 random grants", cbr_cnt - base, acc);

    while (!ref_req) @(negedge clk);
    sleep_req = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(ready && !ref_active, "R9 sleep with debt", {ready, ref_active}, 2);
    end
    sleep_req = 0;
    clear_debt();

    while ((cyc - r0) % T_REF != 5) @(negedge clk);
    clear_debt();
    base = cbr_cnt; bself = self_cnt;
    sleep_req = 1;
    @(negedge clk);
    chk(!ready, "R10 ready drops", ready, 0);
    chk(!cas_n && ras_n && ref_active, "R10 entry start", {ras_n, cas_n, ref_active}, 5);
    repeat (BURST_ROWS * T_CBR + 2 * T_RASS) @(negedge clk);
    chk(!ready && !ras_n && !cas_n, "R10 held in self", {ready, ras_n, cas_n}, 0);
    sleep_req = 0; t0 = cyc;
    while (!ready) @(negedge clk);
    chk(cbr_cnt - base == 2 * BURST_ROWS, "R10 R11 bursts", cbr_cnt - base, 2 * BURST_ROWS);
    chk(self_cnt - bself == 1, "R10 one self entry", self_cnt - bself, 1);
    chk(self_len > T_RASS, "R10 hold follows sleep", self_len, T_RASS + 1);
    chk(cyc - t0 >= T_RPS + BURST_ROWS * T_CBR, "R11 exit time", cyc - t0,
        T_RPS + BURST_ROWS * T_CBR);
    chk(!ref_req, "R11 debt cleared", ref_req, 0);

    base = cbr_cnt; bself = self_cnt;
    sleep_req = 1;
    repeat (3) @(negedge clk);
    sleep_req = 0;
    chk(!ready, "R10 short sleep accepted", ready, 0);
    while (!ready) @(negedge clk);
    chk(self_len == T_RASS, "R10 minimum hold", self_len, T_RASS);
    chk(cbr_cnt - base == 2 * BURST_ROWS, "R11 short sleep bursts", cbr_cnt - base,
        2 * BURST_ROWS);

    repeat (20) @(negedge clk);
    chk(we_bad == 0, "R5 we high", we_bad, 0);
    chk(idle_bad == 0, "R12 idle strobes", idle_bad, 0);
    finish_run();
  end

endmodule